// File: doc/BRIEF.md
# Prioritised Interrupt Acknowledge Chain

This block gathers interrupt requests from a row of identical cells, one per device, and presents them to a processor as a single interrupt line. Each cell remembers a request from its device until that request has been serviced. The line is high whenever any cell has a request waiting.

When the processor answers with its active-low acknowledge, the acknowledge enters cell 0 and ripples along the row. A cell with a waiting request keeps the acknowledge. It then drives its own 8-bit vector onto the vector bus for as long as the acknowledge stays low. A cell with nothing waiting hands the acknowledge to the next cell. The final cell keeps the acknowledge unconditionally, so every acknowledge produces a vector.

Priority comes only from a cell's position in the row. The request of the accepting cell is retired when the processor lets the acknowledge go high again.

Top module: `irq_chain_top`

## Requirements
- R1: A high `dev_req[i]` sampled at a rising clock edge makes cell i pending from the next cycle. The cell stays pending until its request is retired (R8).
- R2: `irq_out` is high in a cycle exactly when at least one cell is pending. It therefore goes high one cycle after a request is sampled.
- R3: The acknowledge is taken by the lowest-indexed pending cell, because cell 0 has the highest priority. Cell i's vector is bits [i*8 +: 8] of the `CELL_VECTORS` parameter.
- R4: A cell that is not pending passes the acknowledge on, so that cell never drives the vector bus.
- R5: If no cell is pending when the acknowledge arrives, the last cell (index N_CELLS-1) takes it and its vector is driven.
- R6: An acknowledge begins at the first rising edge at which `ack_n` is sampled low. `vec_oe` goes high one cycle after that edge and stays high while `ack_n` remains low.
- R7: At most one cell holds the acknowledge at any time. `vec_out` carries the vector of that cell.
- R8: When `ack_n` is sampled high after an acknowledge, the accepting cell's request is retired. `vec_oe` drops in the following cycle. Every other pending request is kept.
- R9: Requests that arrive while an acknowledge is held do not change which cell holds it, and `vec_out` stays stable. Those requests are still recorded.
- R10: If a request for the accepting cell is sampled at the same edge that retires its request, the cell stays pending.
- R11: After reset, no cell is pending, `irq_out` is 0, `vec_oe` is 0 and `vec_out` is 0.
- R12: `vec_out` is all zeros in every cycle in which `vec_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_req | input | N_CELLS | Request strobe per device, index 0 highest priority |
| ack_n | input | 1 | Processor interrupt acknowledge, active low |
| irq_out | output | 1 | Shared interrupt line to the processor |
| vec_oe | output | 1 | High while a cell drives the vector bus |
| vec_out | output | VEC_W | Vector of the accepting cell, zero otherwise |

## Verification
The hardest cases to reach from the ports are those where timing coincides. In one, a request for the very cell that holds the acknowledge arrives at the release edge. In another, a higher-priority request arrives in the middle of a held acknowledge. In a third, the acknowledge arrives with nothing pending, so the tail cell has to answer with no request behind it. Directed sequences place `dev_req` and `ack_n` on exactly those edges. A long random phase then mixes sparse requests with acknowledges of random length, against a behavioural model that is compared on every cycle.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    // State of one cell of the chain
    typedef struct packed {
        logic pending;   // request waiting for service
        logic claimed;   // this cell holds the current acknowledge
    } cell_st_t;

    // State of the acknowledge tracker
    typedef struct packed {
        logic active;    // an acknowledge is being held
    } ack_st_t;

endpackage

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
    import irq_chain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ack_n,
    output logic ack_start,
    output logic ack_end
);

    ack_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        ack_start = !ack_n && !st_q.active;
        ack_end   = ack_n && st_q.active;
        if (ack_start) begin
            st_d.active = 1'b1;
        end else if (ack_end) begin
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: an acknowledge starts once, never on two consecutive edges
    a_r6_start_once: assert property (@(posedge clk) disable iff (!rst_n)
        ack_start |=> !ack_start);

    // R8: a release cannot directly follow another release
    a_r8_end_once: assert property (@(posedge clk) disable iff (!rst_n)
        ack_end |=> !ack_end);

endmodule

// File: rtl/irq_cell.sv
module irq_cell
    import irq_chain_pkg::*;
#(
    parameter bit IS_LAST = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic ack_in_i,     // acknowledge has reached this cell this cycle
    input  logic ack_end_i,    // processor released the acknowledge
    output logic ack_pass_o,   // acknowledge handed to the next cell
    output logic pending_o,
    output logic claim_o
);

    cell_st_t st_q, st_d;
    logic     take;

    always_comb begin
        st_d       = st_q;
        take       = ack_in_i && (st_q.pending || IS_LAST);
        ack_pass_o = ack_in_i && !st_q.pending;
        if (take) begin
            st_d.claimed = 1'b1;
        end else if (ack_end_i) begin
            st_d.claimed = 1'b0;
        end
        if (ack_end_i && st_q.claimed) begin
            st_d.pending = 1'b0;
        end
        if (req_i) begin
            st_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending_o = st_q.pending;
    assign claim_o   = st_q.claimed;

    // R1: a sampled request is pending on the next cycle
    a_r1_req_latches: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> pending_o);

    // R8: a cell that drops its claim with no fresh request is no longer pending
    a_r8_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(claim_o) && !$past(req_i)) |-> !pending_o);

    // R4: a cell that was idle when the acknowledge passed does not claim
    a_r4_idle_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_in_i && !pending_o && !IS_LAST) |=> !claim_o);

endmodule

// File: rtl/irq_vec_mux.sv
module irq_vec_mux #(
    parameter int                           N_CELLS      = 4,
    parameter int                           VEC_W        = 8,
    parameter logic [N_CELLS*VEC_W-1:0]     CELL_VECTORS = '0
) (
    input  logic [N_CELLS-1:0] claim_i,
    output logic [VEC_W-1:0]   vec_o,
    output logic               oe_o
);

    always_comb begin
        vec_o = '0;
        for (int i = 0; i < N_CELLS; i++) begin
            if (claim_i[i]) begin
                vec_o = vec_o | CELL_VECTORS[i*VEC_W +: VEC_W];
            end
        end
        oe_o = |claim_i;
    end

endmodule

// File: rtl/irq_chain_top.sv
module irq_chain_top
    import irq_chain_pkg::*;
#(
    parameter int                       N_CELLS      = 4,
    parameter int                       VEC_W        = 8,
    parameter logic [N_CELLS*VEC_W-1:0] CELL_VECTORS = 32'h2347_8AC1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CELLS-1:0] dev_req,
    input  logic               ack_n,
    output logic               irq_out,
    output logic               vec_oe,
    output logic [VEC_W-1:0]   vec_out
);

    localparam int LAST = N_CELLS - 1;

    logic               ack_start;
    logic               ack_end;
    logic [N_CELLS:0]   ack_ripple;
    logic [N_CELLS-1:0] pend;
    logic [N_CELLS-1:0] claims;

    irq_ack_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_n     (ack_n),
        .ack_start (ack_start),
        .ack_end   (ack_end)
    );

    assign ack_ripple[0] = ack_start;

    for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
        irq_cell #(
            .IS_LAST (g == LAST)
        ) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_i      (dev_req[g]),
            .ack_in_i   (ack_ripple[g]),
            .ack_end_i  (ack_end),
            .ack_pass_o (ack_ripple[g+1]),
            .pending_o  (pend[g]),
            .claim_o    (claims[g])
        );
    end

    irq_vec_mux #(
        .N_CELLS      (N_CELLS),
        .VEC_W        (VEC_W),
        .CELL_VECTORS (CELL_VECTORS)
    ) u_mux (
        .claim_i (claims),
        .vec_o   (vec_out),
        .oe_o    (vec_oe)
    );

    assign irq_out = |pend;

    // R7: never more than one cell holds the acknowledge
    a_r7_one_holder: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claims));

    // R2: any sampled request raises the shared line next cycle
    a_r2_line_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_req) |=> irq_out);

    // R5: an acknowledge that falls off the end is taken by the tail cell
    a_r5_tail_takes: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ripple[N_CELLS] |=> claims[LAST]);

    // R6: the bus is driven one cycle after the acknowledge starts
    a_r6_oe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ack_start |=> vec_oe);

    // R9: a held acknowledge keeps the same vector
    a_r9_vector_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe && !ack_n) |=> (vec_oe && $stable(vec_out)));

    // R12: bus is quiet when not driven
    a_r12_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_oe |-> (vec_out == '0));

endmodule

// File: tb/irq_chain_top_tb.sv
module irq_chain_top_tb;

    localparam int             N   = 4;
    localparam int             VW  = 8;
    localparam logic [N*VW-1:0] VECS = 32'h2347_8AC1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  dev_req = '0;
    logic          ack_n = 1'b1;
    logic          irq_out;
    logic          vec_oe;
    logic [VW-1:0] vec_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    irq_chain_top #(.N_CELLS(N), .VEC_W(VW), .CELL_VECTORS(VECS)) u_dut (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .ack_n(ack_n),
        .irq_out(irq_out), .vec_oe(vec_oe), .vec_out(vec_out)
    );

    // behavioural reference model
    logic [N-1:0] m_pend;
    int           m_claim;
    bit           m_active;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend = '0; m_claim = -1; m_active = 0;
        end else begin
            logic [N-1:0] clr;
            int nc;
            clr = '0;
            nc  = m_claim;
            if (!ack_n && !m_active) begin
                m_active = 1;
                nc = N - 1;
                for (int i = N - 1; i >= 0; i--) if (m_pend[i]) nc = i;
            end else if (ack_n && m_active) begin
                m_active = 0;
                if (m_claim >= 0) clr[m_claim] = 1'b1;
                nc = -1;
            end
            m_pend  = (m_pend & ~clr) | dev_req;
            m_claim = nc;
        end
    end

    function automatic logic [VW-1:0] vec_of(int idx);
        return (idx < 0) ? '0 : VECS[idx*VW +: VW];
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // advance to the next falling edge and compare against the model
    task automatic cyc();
        @(negedge clk);
        check("R2 irq_out vs model", irq_out, (m_pend != 0));
        check("R6 vec_oe vs model", vec_oe, (m_claim >= 0));
        check("R3/R12 vec_out vs model", vec_out, vec_of(m_claim));
    endtask

    task automatic pulse_req(logic [N-1:0] r);
        dev_req = r; cyc(); dev_req = '0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 irq_out reset", irq_out, 0);
        check("R11 vec_oe reset", vec_oe, 0);
        check("R11 vec_out reset", vec_out, 0);
        rst_n = 1'b1;
        cyc();

        // R1 R2 R4: single request on cell 2, cells 0 and 1 pass
        pulse_req(4'b0100);
        check("R1 R2 irq after request", irq_out, 1);
        ack_n = 1'b0; cyc();
        check("R6 oe after ack", vec_oe, 1);
        check("R4 cells 0,1 pass, cell 2 vector", vec_out, 8'h47);
        cyc();
        check("R6 oe held while ack low", vec_oe, 1);
        ack_n = 1'b1; cyc();
        check("R8 oe drops after release", vec_oe, 0);
        check("R8 irq clears", irq_out, 0);

        // R3 R8: cells 1 and 3 pending
        pulse_req(4'b1010);
        ack_n = 1'b0; cyc();
        check("R3 lowest index wins", vec_out, 8'h8A);
        ack_n = 1'b1; cyc();
        check("R8 other request kept", irq_out, 1);
        ack_n = 1'b0; cyc();
        check("R3 remaining cell 3", vec_out, 8'h23);
        ack_n = 1'b1; cyc();
        check("R8 all retired", irq_out, 0);

        // R5: acknowledge with nothing pending
        ack_n = 1'b0; cyc();
        check("R5 tail cell answers", vec_oe, 1);
        check("R5 tail vector", vec_out, 8'h23);
        ack_n = 1'b1; cyc();
        check("R5 no pending after spurious ack", irq_out, 0);

        // R9: higher priority request during held ack
        pulse_req(4'b0100);
        ack_n = 1'b0; cyc();
        dev_req = 4'b0001; cyc(); dev_req = '0;
        cyc();
        check("R9 vector unchanged", vec_out, 8'h47);
        ack_n = 1'b1; cyc();
        check("R9 late request recorded", irq_out, 1);
        ack_n = 1'b0; cyc();
        check("R9 late request served next", vec_out, 8'hC1);

        // R10: request for accepting cell at the release edge
        ack_n = 1'b1; dev_req = 4'b0001; cyc(); dev_req = '0;
        check("R10 request survives release", irq_out, 1);
        ack_n = 1'b0; cyc();
        check("R10 same cell again", vec_out, 8'hC1);
        ack_n = 1'b1; cyc();
        check("R10 finally retired", irq_out, 0);

        // random phase, model comparison every cycle (R7 R12)
        for (int k = 0; k < 4000; k++) begin
            dev_req = (($urandom % 4) == 0) ? N'($urandom) : '0;
            if (($urandom % 3) == 0) ack_n = ~ack_n;
            cyc();
        end
        dev_req = '0; ack_n = 1'b1;
        cyc(); cyc();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule